// File: doc/BRIEF.md
# Disc Mechanism Nibble Command Interface

This block sits on the drive-controller side of a narrow host link. The host writes commands one 4-bit nibble at a time, and the block answers every written nibble with one response nibble. The host polls that nibble through an 8-bit read value whose top bit marks it as fresh. A command is a short nibble string closed by an F terminator. The parser recognises three kinds of string:
- control words led by D;
- a minutes/seconds/frames seek led by B;
- a track/index seek led by C.

Once a complete, known command is seen, the block pulses a strobe together with an 8-bit command code and any seek argument. Mechanics are left to whatever listens to that strobe.

Two D-led codes are requests. After the terminator of a request, the host keeps writing placeholder nibbles, and each one is answered with the next nibble of a payload. The payload is either 8 bytes of subcode Q data or a 5-nibble status word. It is captured from parallel inputs at the moment the request's terminator arrives. A final F closes the reply. Malformed or unknown strings raise an error flag, and the parser resynchronises on F.

The state machine has seven states:
- **IDLE**: waits for a lead nibble. D goes to CODE, B or C goes to ARGS, F is an empty command, and any other value goes to DRAIN.
- **CODE**: collects two code nibbles, then goes to TERM. An F here is an error and returns to IDLE.
- **ARGS**: collects the seek digits, then goes to TERM. An F here is an error and returns to IDLE.
- **TERM**: expects F.
  - For a known code it fires the strobe. A request goes on to PAYLOAD; any other command returns to IDLE.
  - An unknown code flags an error and returns to IDLE.
  - A non-F nibble flags an error and goes to DRAIN.
- **PAYLOAD**: answers with payload nibbles, then goes to PAYEND.
- **PAYEND**: an F returns to IDLE; anything else flags an error and goes to DRAIN.
- **DRAIN**: swallows nibbles until F, then returns to IDLE.

Top module: `nib_cmd_responder`

## Requirements
- R1: After reset, rd_data is 0x00, cmd_stb is 0 and err is 0.
- R2: Every accepted write makes rd_data equal to {1, 000, response nibble} from the next cycle on. A read pulse with no write in the same cycle clears bit 7 and leaves the nibble unchanged.
- R3: Every command nibble and every terminator is answered with F. A control command therefore draws four F answers, a time seek eight, and a track seek six.
- R4: The known D codes are 01–04, 10–13, 40–46, 50 and 51. When the terminator of D x y F arrives, cmd_stb is high for exactly one cycle with cmd_code = {x, y} (x in bits 7:4) and cmd_arg = 0.
- R5: B followed by six digits and F strobes cmd_code 0xB0, with cmd_arg holding the six digits in arrival order, the first in bits 23:20.
- R6: C followed by four digits and F strobes cmd_code 0xC0, with cmd_arg[15:0] holding the digits in arrival order and cmd_arg[23:16] zero.
- R7: After D50F, the next 16 writes of any value are answered with q_data nibbles, bits 63:60 first. The following write of F is answered with F, and the parser is then idle.
- R8: After D51F, the next 5 writes are answered with status_word nibbles, bits 19:16 first, passed through unaltered. In that word 00 or FF in the top byte marks an audio or data disc, and the middle nibble carries the disc state. A closing F is answered with F.
- R9: The payload is captured in the cycle the request's terminator is written. Later changes of q_data or status_word do not alter the reply in progress.
- R10: A lead nibble other than B, C, D or F, or an unlisted D code, sets err and produces no strobe. The parser is idle again after the next F. The first nibble of the following command clears err. A lone F in idle is answered with F and does nothing else.
- R11: An F arriving before all code or seek digits sets err and returns the parser to idle at once. A non-F where a terminator is expected sets err, and every nibble up to and including the next F is then swallowed without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host writes one nibble this cycle |
| wr_nib | input | 4 | Written command nibble |
| rd_en | input | 1 | Host reads the response register this cycle |
| q_data | input | 64 | Subcode Q data, 16 nibbles |
| status_word | input | 20 | 5-nibble drive status |
| rd_data | output | 8 | {ready, 000, response nibble} |
| cmd_stb | output | 1 | One-cycle pulse on a complete known command |
| cmd_code | output | 8 | Decoded command code |
| cmd_arg | output | 24 | Seek digits, earliest digit highest |
| err | output | 1 | Malformed or unknown command seen |

## Verification
The known-code check is tried by sweeping every D x y pair with x from 0 to 5 and y from 0 to 7. This separates listed codes from near neighbours such as 05, 14 and 47, which must raise err instead of strobing. Seeks and requests use random BCD digits, Q bytes and status words from a seeded generator. The payload inputs are re-randomised right after each request's terminator, so a design that reads the inputs live rather than capturing them is caught. Directed strings cover the remaining cases:
- a bad lead nibble;
- an early F inside a seek;
- a missing terminator followed by a drain that contains a D-led string that must not strobe;
- a lone F in idle;
- a read pulse that clears the ready bit.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CODE,
        ST_ARGS,
        ST_TERM,
        ST_PAYLOAD,
        ST_PAYEND,
        ST_DRAIN
    } state_t;

    localparam logic [3:0] NIB_TERM  = 4'hF;
    localparam logic [3:0] NIB_CTRL  = 4'hD;
    localparam logic [3:0] NIB_TIME  = 4'hB;
    localparam logic [3:0] NIB_TRACK = 4'hC;

    localparam logic [7:0] CODE_QREQ  = 8'h50;
    localparam logic [7:0] CODE_STREQ = 8'h51;
    localparam logic [7:0] CODE_TIME  = 8'hB0;
    localparam logic [7:0] CODE_TRACK = 8'hC0;

endpackage

// File: rtl/nibcmd_code_check.sv
module nibcmd_code_check (
    input  logic [7:0] code,
    output logic       known,
    output logic       is_qreq,
    output logic       is_streq
);
    import nibcmd_pkg::*;

    logic [3:0] hi;
    logic [3:0] lo;

    always_comb begin
        hi = code[7:4];
        lo = code[3:0];
        unique case (hi)
            4'h0:    known = (lo >= 4'h1) && (lo <= 4'h4);
            4'h1:    known = (lo <= 4'h3);
            4'h4:    known = (lo <= 4'h6);
            4'h5:    known = (lo <= 4'h1);
            default: known = 1'b0;
        endcase
        is_qreq  = (code == CODE_QREQ);
        is_streq = (code == CODE_STREQ);
    end

endmodule

// File: rtl/nibcmd_payload.sv
module nibcmd_payload #(
    parameter int Q_NIBS  = 16,
    parameter int ST_NIBS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_q,
    input  logic                 load_st,
    input  logic                 shift,
    input  logic [4*Q_NIBS-1:0]  q_in,
    input  logic [4*ST_NIBS-1:0] st_in,
    output logic [3:0]           head
);
    localparam int PAY_W = 4 * Q_NIBS;
    localparam int PAD_W = 4 * (Q_NIBS - ST_NIBS);

    logic [PAY_W-1:0] pay;
    logic [PAY_W-1:0] st_aligned;

    generate
        if (PAD_W > 0) begin : g_pad
            assign st_aligned = {st_in, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign st_aligned = st_in[PAY_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay <= '0;
        end else if (load_q) begin
            pay <= q_in;
        end else if (load_st) begin
            pay <= st_aligned;
        end else if (shift) begin
            pay <= {pay[PAY_W-5:0], 4'h0};
        end
    end

    assign head = pay[PAY_W-1:PAY_W-4];

endmodule

// File: rtl/nibcmd_resp_reg.sv
module nibcmd_resp_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] nib_in,
    output logic [7:0] rd_data
);
    logic       rdy;
    logic [3:0] nib;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
            nib <= 4'h0;
        end else if (wr_en) begin
            rdy <= 1'b1;
            nib <= nib_in;
        end else if (rd_en) begin
            rdy <= 1'b0;
        end
    end

    assign rd_data = {rdy, 3'b000, nib};

    assert_ready_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[7]);
    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !rd_data[7]);
    assert_nib_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[3:0]));

endmodule

// File: rtl/nib_cmd_responder.sv
module nib_cmd_responder #(
    parameter int Q_NIBS     = 16,
    parameter int ST_NIBS    = 5,
    parameter int TIME_NIBS  = 6,
    parameter int TRACK_NIBS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [3:0]             wr_nib,
    input  logic                   rd_en,
    input  logic [4*Q_NIBS-1:0]    q_data,
    input  logic [4*ST_NIBS-1:0]   status_word,
    output logic [7:0]             rd_data,
    output logic                   cmd_stb,
    output logic [7:0]             cmd_code,
    output logic [4*TIME_NIBS-1:0] cmd_arg,
    output logic                   err
);
    import nibcmd_pkg::*;

    localparam int ARG_W = 4 * TIME_NIBS;
    localparam int MAX_N = (Q_NIBS > TIME_NIBS) ? Q_NIBS : TIME_NIBS;
    localparam int CNT_W = $clog2(MAX_N + 1);

    state_t           state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n, need, need_n;
    logic [7:0]       code_r, code_n;
    logic [ARG_W-1:0] arg_r, arg_n;
    logic             seek_r, seek_n;
    logic [3:0]       resp_nib, head;
    logic             stb_n, err_set, err_clr, load_q, load_st, shift;
    logic             known, is_qreq, is_streq;

    nibcmd_code_check u_check (
        .code     (code_r),
        .known    (known),
        .is_qreq  (is_qreq),
        .is_streq (is_streq)
    );

    nibcmd_payload #(.Q_NIBS(Q_NIBS), .ST_NIBS(ST_NIBS)) u_payload (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_q  (load_q),
        .load_st (load_st),
        .shift   (shift),
        .q_in    (q_data),
        .st_in   (status_word),
        .head    (head)
    );

    nibcmd_resp_reg u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .nib_in  (resp_nib),
        .rd_data (rd_data)
    );

    // Next-state and per-nibble decisions
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        need_n   = need;
        code_n   = code_r;
        arg_n    = arg_r;
        seek_n   = seek_r;
        resp_nib = NIB_TERM;
        stb_n    = 1'b0;
        err_set  = 1'b0;
        err_clr  = 1'b0;
        load_q   = 1'b0;
        load_st  = 1'b0;
        shift    = 1'b0;
        if (wr_en) begin
            unique case (state)
                ST_IDLE: begin
                    err_clr = 1'b1;
                    cnt_n   = '0;
                    arg_n   = '0;
                    if (wr_nib == NIB_CTRL) begin
                        state_n = ST_CODE;
                        code_n  = 8'h00;
                        seek_n  = 1'b0;
                    end else if (wr_nib == NIB_TIME) begin
                        state_n = ST_ARGS;
                        code_n  = CODE_TIME;
                        seek_n  = 1'b1;
                        need_n  = CNT_W'(TIME_NIBS - 1);
                    end else if (wr_nib == NIB_TRACK) begin
                        state_n = ST_ARGS;
                        code_n  = CODE_TRACK;
                        seek_n  = 1'b1;
                        need_n  = CNT_W'(TRACK_NIBS - 1);
                    end else if (wr_nib != NIB_TERM) begin
                        state_n = ST_DRAIN;
                        err_set = 1'b1;
                    end
                end
                ST_CODE: begin
                    if (wr_nib == NIB_TERM) begin
                        err_set = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        code_n = {code_r[3:0], wr_nib};
                        if (cnt == CNT_W'(1)) state_n = ST_TERM;
                        else cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_ARGS: begin
                    if (wr_nib == NIB_TERM) begin
                        err_set = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        arg_n = {arg_r[ARG_W-5:0], wr_nib};
                        if (cnt == need) state_n = ST_TERM;
                        else cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_TERM: begin
                    if (wr_nib != NIB_TERM) begin
                        err_set = 1'b1;
                        state_n = ST_DRAIN;
                    end else if (seek_r || known) begin
                        stb_n   = 1'b1;
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                        if (!seek_r && is_qreq) begin
                            load_q  = 1'b1;
                            state_n = ST_PAYLOAD;
                            need_n  = CNT_W'(Q_NIBS - 1);
                        end else if (!seek_r && is_streq) begin
                            load_st = 1'b1;
                            state_n = ST_PAYLOAD;
                            need_n  = CNT_W'(ST_NIBS - 1);
                        end
                    end else begin
                        err_set = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
                ST_PAYLOAD: begin
                    resp_nib = head;
                    shift    = 1'b1;
                    if (cnt == need) state_n = ST_PAYEND;
                    else cnt_n = cnt + CNT_W'(1);
                end
                ST_PAYEND: begin
                    if (wr_nib == NIB_TERM) begin
                        state_n = ST_IDLE;
                    end else begin
                        err_set = 1'b1;
                        state_n = ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (wr_nib == NIB_TERM) state_n = ST_IDLE;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            need   <= '0;
            code_r <= '0;
            arg_r  <= '0;
            seek_r <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            need   <= need_n;
            code_r <= code_n;
            arg_r  <= arg_n;
            seek_r <= seek_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
            cmd_arg  <= '0;
            err      <= 1'b0;
        end else begin
            cmd_stb <= stb_n;
            if (stb_n) begin
                cmd_code <= code_r;
                cmd_arg  <= arg_r;
            end
            if (err_set) err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    assert_stb_after_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(wr_en && (wr_nib == NIB_TERM)));
    assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    assert_stb_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !err);
    assert_err_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(wr_en));
    assert_payload_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD) |-> (cnt <= need));
    assert_drain_no_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> !cmd_stb);

endmodule

// File: tb/nib_cmd_responder_tb.sv
`timescale 1ns/1ps
module nib_cmd_responder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_nib = 4'h0;
    logic        rd_en = 1'b0;
    logic [63:0] q_data = '0;
    logic [19:0] status_word = '0;
    logic [7:0]  rd_data;
    logic        cmd_stb;
    logic [7:0]  cmd_code;
    logic [23:0] cmd_arg;
    logic        err;

    int total = 0;
    int bad = 0;

    logic [7:0]  r_data;
    logic        r_stb;
    logic [7:0]  r_code;
    logic [23:0] r_arg;
    logic        r_err;

    always #5 clk = ~clk;

    nib_cmd_responder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_nib(wr_nib), .rd_en(rd_en),
        .q_data(q_data), .status_word(status_word), .rd_data(rd_data),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_arg(cmd_arg), .err(err)
    );

    function automatic bit exp_known(input logic [3:0] hi, input logic [3:0] lo);
        return (hi == 4'h0 && lo >= 4'h1 && lo <= 4'h4) ||
               (hi == 4'h1 && lo <= 4'h3) ||
               (hi == 4'h4 && lo <= 4'h6) ||
               (hi == 4'h5 && lo <= 4'h1);
    endfunction

    function automatic logic [3:0] bcd_digit();
        return 4'($urandom_range(0, 9));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] n);
        @(negedge clk);
        wr_en = 1'b1;
        wr_nib = n;
        @(posedge clk);
        #1;
        r_data = rd_data; r_stb = cmd_stb; r_code = cmd_code;
        r_arg = cmd_arg; r_err = err;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_ack(input logic [3:0] n, input string tag);
        send(n);
        check(tag, {24'h0, r_data}, 32'h8F);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] digits;
        logic [63:0] qv;
        logic [19:0] sv;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check("R1 rd_data", {24'h0, rd_data}, 32'h0);
        check("R1 cmd_stb", {31'h0, cmd_stb}, 32'h0);
        check("R1 err", {31'h0, err}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R4 directed control command plus R2 read clear
        send_ack(4'hD, "R3 D01F lead");
        send_ack(4'h0, "R3 D01F x");
        send_ack(4'h1, "R3 D01F y");
        send_ack(4'hF, "R3 D01F term");
        check("R4 stb D01", {31'h0, r_stb}, 32'h1);
        check("R4 code D01", {24'h0, r_code}, 32'h01);
        @(posedge clk); #1;
        check("R4 stb one cycle", {31'h0, cmd_stb}, 32'h0);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        #1;
        check("R2 read clears ready", {24'h0, rd_data}, 32'h0F);

        // R4/R10 sweep of D codes
        for (int hi = 0; hi < 6; hi++) begin
            for (int lo = 0; lo < 8; lo++) begin
                bit k;
                k = exp_known(4'(hi), 4'(lo));
                send_ack(4'hD, "R3 sweep lead");
                check("R10 err cleared by lead", {31'h0, r_err}, 32'h0);
                send_ack(4'(hi), "R3 sweep x");
                send_ack(4'(lo), "R3 sweep y");
                send_ack(4'hF, "R3 sweep term");
                check("R4 sweep stb", {31'h0, r_stb}, {31'h0, k});
                check("R10 sweep err", {31'h0, r_err}, {31'h0, !k});
                if (k) begin
                    check("R4 sweep code", {24'h0, r_code}, {24'h0, 4'(hi), 4'(lo)});
                    check("R4 sweep arg", {8'h0, r_arg}, 32'h0);
                end
                if (k && hi == 5) begin
                    // close the request with placeholders and F
                    repeat (lo == 0 ? 16 : 5) send(4'h0);
                    send_ack(4'hF, "R7 sweep close");
                end
            end
        end

        // R5 time seek
        for (int i = 0; i < 20; i++) begin
            digits = '0;
            send_ack(4'hB, "R3 time lead");
            for (int d = 0; d < 6; d++) begin
                logic [3:0] g;
                g = bcd_digit();
                digits = {digits[19:0], g};
                send_ack(g, "R3 time digit");
            end
            send_ack(4'hF, "R3 time term");
            check("R5 time stb", {31'h0, r_stb}, 32'h1);
            check("R5 time code", {24'h0, r_code}, 32'hB0);
            check("R5 time arg", {8'h0, r_arg}, {8'h0, digits});
        end

        // R6 track seek
        for (int i = 0; i < 20; i++) begin
            digits = '0;
            send_ack(4'hC, "R3 track lead");
            for (int d = 0; d < 4; d++) begin
                logic [3:0] g;
                g = bcd_digit();
                digits = {digits[19:0], g};
                send_ack(g, "R3 track digit");
            end
            send_ack(4'hF, "R3 track term");
            check("R6 track stb", {31'h0, r_stb}, 32'h1);
            check("R6 track code", {24'h0, r_code}, 32'hC0);
            check("R6 track arg", {8'h0, r_arg}, {8'h0, digits});
        end

        // R7/R9 Q data
        for (int i = 0; i < 8; i++) begin
            qv = {$urandom, $urandom};
            q_data = qv;
            send(4'hD); send(4'h5); send(4'h0);
            send_ack(4'hF, "R3 qreq term");
            check("R7 qreq code", {24'h0, r_code}, 32'h50);
            q_data = {$urandom, $urandom};
            for (int n = 0; n < 16; n++) begin
                send(4'(n));
                check("R9 R7 q nibble", {24'h0, r_data}, {24'h0, 4'h8, qv[63-4*n -: 4]});
            end
            send_ack(4'hF, "R7 q close");
        end

        // R8/R9 status
        for (int i = 0; i < 8; i++) begin
            sv = {(i % 2 == 0) ? 8'h00 : 8'hFF, 4'($urandom_range(0, 4)), 8'($urandom)};
            status_word = sv;
            send(4'hD); send(4'h5); send(4'h1);
            send_ack(4'hF, "R3 streq term");
            check("R8 streq code", {24'h0, r_code}, 32'h51);
            status_word = 20'($urandom);
            for (int n = 0; n < 5; n++) begin
                send(4'h0);
                check("R9 R8 status nibble", {24'h0, r_data}, {24'h0, 4'h8, sv[19-4*n -: 4]});
            end
            send_ack(4'hF, "R8 status close");
        end

        // R10 bad lead, drain, lone F
        send_ack(4'h7, "R10 bad lead ack");
        check("R10 bad lead err", {31'h0, r_err}, 32'h1);
        send_ack(4'hD, "R10 drain D");
        send_ack(4'h0, "R10 drain 0");
        send_ack(4'h2, "R10 drain 2");
        send_ack(4'hF, "R10 drain end");
        check("R10 no stb in drain", {31'h0, r_stb}, 32'h0);
        send_ack(4'hF, "R10 lone F");
        check("R10 lone F no stb", {31'h0, r_stb}, 32'h0);
        send_ack(4'hD, "R10 recover lead");
        check("R10 err cleared", {31'h0, r_err}, 32'h0);
        send(4'h0); send(4'h2); send(4'hF);
        check("R10 recover stb", {31'h0, r_stb}, 32'h1);
        check("R10 recover code", {24'h0, r_code}, 32'h02);

        // R11 early F in seek
        send(4'hB); send(4'h1); send(4'h2);
        send_ack(4'hF, "R11 early F ack");
        check("R11 early F err", {31'h0, r_err}, 32'h1);
        check("R11 early F no stb", {31'h0, r_stb}, 32'h0);
        send(4'hD); send(4'h0); send(4'h3); send(4'hF);
        check("R11 idle after early F", {24'h0, r_code, 7'h0, r_stb}, 32'h0301);

        // R11 missing terminator then drain containing a D string
        send(4'hD); send(4'h0); send(4'h2);
        send_ack(4'h5, "R11 missing term ack");
        check("R11 missing term err", {31'h0, r_err}, 32'h1);
        send(4'hD); send(4'h0); send(4'h3);
        send_ack(4'hF, "R11 drain end");
        check("R11 drain no stb", {31'h0, r_stb}, 32'h0);
        send(4'hD); send(4'h0); send(4'h4); send(4'hF);
        check("R11 after drain stb", {31'h0, r_stb}, 32'h1);
        check("R11 after drain code", {24'h0, r_code}, 32'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule